// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit timing channels that share one count-enable strobe. Each channel has its own gate input and output line. Software reaches the channels through a byte-wide port with four addresses. Addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 takes control words. A control word picks one channel and sets three things for it: its counting mode, whether counts are binary or BCD, and how the 16-bit count is moved over the byte bus. The byte access can be low byte only, high byte only, or low byte then high byte. A control word can instead order a latch, which freezes the channel's count so that it can be read back safely.

Each channel keeps its loaded terminal value and the number of enabled ticks since the last load or retrigger. The output waveform is computed from those two values, so it never goes through a separate down-counter reload path. There are six waveform families: interrupt on terminal count, one-shot, rate generator, square wave, software strobe and hardware strobe. Channel 0's output also drives a level-sensitive interrupt request.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset every channel is in mode 3, binary, word access (byte toggle on the low byte), with terminal 65536 and zero elapsed ticks. Every output is high and a data read returns 0x00.
- R2: The elapsed count of a channel advances by one only on a clock edge where tick_en is 1. With tick_en at 0 the outputs and the readback count hold.
- R3: A load takes effect at the clock edge that accepts the completing data byte and sets the elapsed count to zero. A loaded raw value of 0 means 65536 in binary and 10000 in BCD.
- R4: With d elapsed ticks and terminal N, mode 0 drives the output low while d<N and high once d>=N. Mode 1 drives it high while d<N and low from then on.
- R5: Mode 2 (code 2 or 6) repeats with period N. The output is low only when d is a nonzero multiple of N.
- R6: Mode 3 (code 3 or 7) drives the output high while (d mod N) < (N+1)>>1 and low otherwise. An odd N therefore gets one extra high tick.
- R7: Modes 4 and 5 hold the output high except while d equals N exactly. The output is then low for one tick and stays high afterwards.
- R8: A rising edge on a channel's gate sets its elapsed count to zero in modes 1, 2, 3 and 5 (codes 1,2,3,5,6,7). In modes 0 and 4 it has no effect.
- R9: The control word at address 3 has these fields: bits 7:6 select the channel (3 is ignored); bits 5:4 are 00 latch, 01 low byte, 10 high byte, 11 low then high; bits 3:1 are the mode; bit 0 selects BCD. Any control word for a channel returns its byte toggle to the low byte. In word access each data read or write flips the toggle. A load happens on the high-byte write, and it uses the low byte stored by the write before it.
- R10: A latch command captures the channel's count as it stood before that clock edge. The captured value is returned until the access pattern's last byte has been read. A latch command while a value is held is ignored.
- R11: The readback count is N minus d, as the low 16 bits. In modes 2 and 3, d is taken modulo N. In the other modes d stops at N.
- R12: In BCD, the loaded value is taken as four decimal digits and the readback count is returned as four decimal digits.
- R13: irq always equals channel 0's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count enable shared by all channels |
| gate | input | NUM_CH | Per-channel gate, sampled each clock |
| addr | input | 2 | Port select: 0..2 channel data, 3 control |
| wr_en | input | 1 | Write strobe for wdata at addr |
| rd_en | input | 1 | Read strobe; read side effects apply at the edge |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, valid during the rd_en cycle |
| out | output | NUM_CH | Channel output lines |
| irq | output | 1 | Interrupt request, level of channel 0 output |

## Verification
A latch command and a counting tick can land on the same clock edge. The latch must capture the count from before that edge, while the elapsed count moves on underneath it. The bench loads channel 0 with 0x0300 and lets it run ten ticks with tick_en held high. It then issues a latch and expects exactly 0x02F6 back over two byte reads. A second latch that is sent while the first value is still held must leave that value unchanged. Once the held value has been read, reads must return the live count again, and the bench checks it at the exact tick of each read.

// File: rtl/pit_pkg.sv
// Package: shared widths, access-pattern encoding and BCD conversion helpers
// for the interval timer. Assumes a 16-bit count moved over an 8-bit bus.
package pit_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int TERM_W = CNT_W + 1;          // holds 65536
    localparam int BCD_DIGITS = CNT_W / 4;
    localparam int BCD_MAX    = 10000;

    // Byte access pattern carried in control bits 5:4
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef logic [2:0] mode_t;

    // Decode four BCD digits into a binary value (digits assumed valid)
    function automatic logic [TERM_W-1:0] bcd_to_bin(input logic [CNT_W-1:0] v);
        logic [TERM_W-1:0] acc;
        acc = '0;
        for (int k = BCD_DIGITS - 1; k >= 0; k--) begin
            acc = acc * TERM_W'(10) + TERM_W'(v[k*4 +: 4]);
        end
        return acc;
    endfunction

    // Encode a binary value (at most 10000) as BCD, keeping the low four digits
    function automatic logic [CNT_W-1:0] bin_to_bcd(input logic [TERM_W-1:0] v);
        logic [CNT_W+3:0] bcd;
        bcd = '0;
        for (int i = 13; i >= 0; i--) begin
            for (int d = 0; d <= BCD_DIGITS; d++) begin
                if (bcd[d*4 +: 4] >= 4'd5) bcd[d*4 +: 4] = bcd[d*4 +: 4] + 4'd3;
            end
            bcd = {bcd[CNT_W+2:0], v[i]};
        end
        return bcd[CNT_W-1:0];
    endfunction
endpackage

// File: rtl/pit_count_core.sv
// Counting core of one channel. Keeps the terminal value and the elapsed
// tick count since the last load or gate retrigger, and derives the output
// waveform and the readback count from them.
// Assumes: load_i and a gate edge are single-cycle qualified by the caller;
// gate_i is already synchronous to clk.
module pit_count_core
    import pit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             gate_i,
    input  mode_t            mode_i,
    input  logic             bcd_i,
    input  logic             load_i,
    input  logic [TERM_W-1:0] load_term_i,
    output logic             out_o,
    output logic [CNT_W-1:0] live_o
);
    logic [TERM_W-1:0] term_q;
    logic [TERM_W-1:0] phase_q;
    logic              past_q;
    logic              started_q;
    logic              gate_q;

    logic              periodic;
    logic              retrig_mode;
    logic              gate_rise;
    logic              restart;
    logic              at_term;
    logic [TERM_W-1:0] half;
    logic [TERM_W-1:0] remain;

    // Classify the mode and detect restart conditions
    always_comb begin
        periodic    = mode_i[1];
        retrig_mode = mode_i[1] | mode_i[0];
        gate_rise   = gate_i & ~gate_q;
        restart     = load_i | (gate_rise & retrig_mode);
        at_term     = (phase_q == term_q);
        half        = (term_q + TERM_W'(1)) >> 1;
        remain      = term_q - phase_q;
    end

    // Terminal, elapsed count and flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q    <= TERM_W'(1) << CNT_W;
            phase_q   <= '0;
            past_q    <= 1'b0;
            started_q <= 1'b0;
            gate_q    <= gate_i;
        end else begin
            gate_q <= gate_i;
            if (load_i) term_q <= load_term_i;
            if (restart) begin
                phase_q   <= '0;
                past_q    <= 1'b0;
                started_q <= 1'b0;
            end else if (tick_i) begin
                if (periodic) begin
                    phase_q   <= (phase_q >= term_q - TERM_W'(1)) ? '0 : phase_q + TERM_W'(1);
                    started_q <= 1'b1;
                end else if (at_term) begin
                    past_q <= 1'b1;
                end else begin
                    phase_q <= phase_q + TERM_W'(1);
                end
            end
        end
    end

    // Output waveform per mode
    always_comb begin
        case (mode_i)
            3'd0:       out_o = at_term;
            3'd1:       out_o = ~at_term;
            3'd2, 3'd6: out_o = ~((phase_q == '0) & started_q);
            3'd3, 3'd7: out_o = (phase_q < half);
            default:    out_o = ~(at_term & ~past_q);
        endcase
    end

    // Readback count in the selected number format
    always_comb begin
        live_o = bcd_i ? bin_to_bcd(remain) : remain[CNT_W-1:0];
    end

    // R7
    strobe_one_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == 3'd4 || mode_i == 3'd5) && !out_o && tick_i && !restart)
        |=> (out_o || mode_i != $past(mode_i)));

    // R5
    rate_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd2 && !out_o && tick_i && !restart && term_q > TERM_W'(1))
        |=> (out_o || mode_i != $past(mode_i)));

    // R3
    load_clears_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && mode_i == 3'd0) |=> !out_o);

    // R11
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= term_q);
endmodule

// File: rtl/pit_host_regs.sv
// Host-side slice of one channel: control fields, byte toggle, low-byte
// holding register for word loads, and the count latch for readback.
// Assumes: at most one of ctl_wr_i, latch_i, data_wr_i, data_rd_i per cycle.
module pit_host_regs
    import pit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr_i,
    input  logic              latch_i,
    input  mode_t             cfg_mode_i,
    input  logic              cfg_bcd_i,
    input  acc_e              cfg_acc_i,
    input  logic              data_wr_i,
    input  logic              data_rd_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic [CNT_W-1:0]  live_i,
    output mode_t             mode_o,
    output logic              bcd_o,
    output logic              load_o,
    output logic [TERM_W-1:0] load_term_o,
    output logic [BYTE_W-1:0] rdata_o
);
    acc_e              acc_q;
    logic              tog_q;
    logic [BYTE_W-1:0] lo_q;
    logic [CNT_W-1:0]  latch_q;
    logic              lvld_q;
    logic [CNT_W-1:0]  raw;
    logic [CNT_W-1:0]  src;

    // Assemble the raw count and decide whether this write completes a load
    always_comb begin
        case (acc_q)
            ACC_LO:  raw = {{BYTE_W{1'b0}}, wdata_i};
            ACC_HI:  raw = {wdata_i, {BYTE_W{1'b0}}};
            default: raw = {wdata_i, lo_q};
        endcase
        load_o = data_wr_i & ((acc_q == ACC_LO) | (acc_q == ACC_HI) |
                              ((acc_q == ACC_WORD) & tog_q));
    end

    // Convert the raw count to a terminal value, mapping zero to the maximum
    always_comb begin
        if (bcd_o)
            load_term_o = (raw == '0) ? TERM_W'(BCD_MAX) : bcd_to_bin(raw);
        else
            load_term_o = (raw == '0) ? (TERM_W'(1) << CNT_W) : {1'b0, raw};
    end

    // Select the read byte from the held or live count
    always_comb begin
        src = lvld_q ? latch_q : live_i;
        case (acc_q)
            ACC_LO:  rdata_o = src[BYTE_W-1:0];
            ACC_HI:  rdata_o = src[CNT_W-1:BYTE_W];
            default: rdata_o = tog_q ? src[CNT_W-1:BYTE_W] : src[BYTE_W-1:0];
        endcase
    end

    // Control fields, byte toggle, holding byte and latch state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o  <= 3'd3;
            bcd_o   <= 1'b0;
            acc_q   <= ACC_WORD;
            tog_q   <= 1'b0;
            lo_q    <= '0;
            latch_q <= '0;
            lvld_q  <= 1'b0;
        end else if (ctl_wr_i) begin
            mode_o <= cfg_mode_i;
            bcd_o  <= cfg_bcd_i;
            acc_q  <= cfg_acc_i;
            tog_q  <= 1'b0;
        end else if (latch_i) begin
            tog_q <= 1'b0;
            if (!lvld_q) begin
                latch_q <= live_i;
                lvld_q  <= 1'b1;
            end
        end else if (data_wr_i) begin
            if (acc_q == ACC_WORD) begin
                tog_q <= ~tog_q;
                if (!tog_q) lo_q <= wdata_i;
            end
        end else if (data_rd_i) begin
            if (acc_q == ACC_WORD) tog_q <= ~tog_q;
            if (lvld_q && (acc_q != ACC_WORD || tog_q)) lvld_q <= 1'b0;
        end
    end

    // R10
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvld_q |=> $stable(latch_q));

    // R9
    ctl_resets_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_i |=> !tog_q);
endmodule

// File: rtl/prog_interval_timer.sv
// Top of the interval timer: decodes the byte port into per-channel control,
// latch, write and read strobes, instantiates one register slice and one
// counting core per channel, and drives the interrupt from channel 0.
// Assumes: NUM_CH is 1..3 (address 3 is the control port); wr_en and rd_en
// are never high together.
module prog_interval_timer
    import pit_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [NUM_CH-1:0] gate,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [NUM_CH-1:0] out,
    output logic              irq
);
    localparam logic [1:0] CTL_ADDR = 2'd3;

    logic              ctl_hit;
    acc_e              cfg_acc;
    logic [NUM_CH-1:0] ctl_wr;
    logic [NUM_CH-1:0] latch_cmd;
    logic [NUM_CH-1:0] data_wr;
    logic [NUM_CH-1:0] data_rd;
    logic [BYTE_W-1:0] ch_rdata [NUM_CH];

    // Decode the control port fields
    always_comb begin
        ctl_hit = wr_en & (addr == CTL_ADDR);
        cfg_acc = acc_e'(wdata[5:4]);
    end

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            mode_t             mode_w;
            logic              bcd_w;
            logic              load_w;
            logic [TERM_W-1:0] term_w;
            logic [CNT_W-1:0]  live_w;

            // Per-channel strobe decode
            always_comb begin
                ctl_wr[i]    = ctl_hit & (wdata[7:6] == 2'(i)) & (cfg_acc != ACC_LATCH);
                latch_cmd[i] = ctl_hit & (wdata[7:6] == 2'(i)) & (cfg_acc == ACC_LATCH);
                data_wr[i]   = wr_en & (addr == 2'(i));
                data_rd[i]   = rd_en & (addr == 2'(i));
            end

            pit_host_regs u_regs (
                .clk         (clk),
                .rst_n       (rst_n),
                .ctl_wr_i    (ctl_wr[i]),
                .latch_i     (latch_cmd[i]),
                .cfg_mode_i  (wdata[3:1]),
                .cfg_bcd_i   (wdata[0]),
                .cfg_acc_i   (cfg_acc),
                .data_wr_i   (data_wr[i]),
                .data_rd_i   (data_rd[i]),
                .wdata_i     (wdata),
                .live_i      (live_w),
                .mode_o      (mode_w),
                .bcd_o       (bcd_w),
                .load_o      (load_w),
                .load_term_o (term_w),
                .rdata_o     (ch_rdata[i])
            );

            pit_count_core u_core (
                .clk         (clk),
                .rst_n       (rst_n),
                .tick_i      (tick_en),
                .gate_i      (gate[i]),
                .mode_i      (mode_w),
                .bcd_i       (bcd_w),
                .load_i      (load_w),
                .load_term_i (term_w),
                .out_o       (out[i]),
                .live_o      (live_w)
            );
        end
    endgenerate

    // Read mux over the channel data ports
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (addr == 2'(i)) rdata = ch_rdata[i];
            end
        end
    end

    // Interrupt request follows channel 0
    always_comb irq = out[0];

    // R9
    host_rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && rd_en));

    // R9
    one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_wr | ctl_wr | latch_cmd));
endmodule

// File: tb/tb_prog_interval_timer.sv
module tb_prog_interval_timer;
    localparam int NCH = 3;
    localparam int WATCHDOG = 20000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick_en = 1'b0;
    logic [NCH-1:0] gate = 3'b011;
    logic [1:0]     addr = '0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [7:0]     wdata = '0;
    logic [7:0]     rdata;
    logic [NCH-1:0] out;
    logic           irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int         kind;   // 0 read byte, 1 channel output, 2 irq
        int         ch;
        logic [7:0] val;
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    prog_interval_timer #(.NUM_CH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
        .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata),
        .rdata(rdata), .out(out), .irq(irq)
    );

    always #2.5 clk = ~clk;

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            logic [7:0] act;
            e = sb_q.pop_front();
            case (e.kind)
                0:       act = rdata;
                1:       act = {7'd0, out[e.ch]};
                default: act = {7'd0, irq};
            endcase
            n_chk++;
            if (act !== e.val) begin
                n_fail++;
                $display("FAIL %s: got %0h expected %0h", e.tag, act, e.val);
            end
        end
    end

    task automatic push(int kind, int ch, logic [7:0] v, string tag);
        exp_t e;
        e.kind = kind; e.ch = ch; e.val = v; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, logic [7:0] e, string tag);
        addr = a; rd_en = 1'b1;
        push(0, 0, e, tag);
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic exp_out(int ch, logic v, string tag);
        push(1, ch, {7'd0, v}, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    // Driver
    initial begin
        step(3);
        rst_n = 1'b1;

        // R1 reset state, R2 no ticks while tick_en is low
        for (int c = 0; c < NCH; c++) exp_out(c, 1'b1, "R1 out high at reset");
        push(2, 0, 8'h01, "R13 irq high at reset");
        step(5);
        rd(2'd0, 8'h00, "R1 count low byte");
        rd(2'd0, 8'h00, "R2 count high byte held");
        tick_en = 1'b1;
        step(3);
        wr(2'd3, 8'h00);                // latch ch0 : 65536-3
        rd(2'd0, 8'hFD, "R2 ticks counted low");
        rd(2'd0, 8'hFF, "R2 ticks counted high");

        // R4 mode 0 on ch0, count 5, word access
        wr(2'd3, 8'h30); wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        exp_out(0, 1'b0, "R4 mode0 low after load");
        push(2, 0, 8'h00, "R13 irq follows out0 low");
        step(4); exp_out(0, 1'b0, "R4 mode0 low at d=4");
        step(1); exp_out(0, 1'b1, "R4 mode0 high at d=5");
        push(2, 0, 8'h01, "R13 irq follows out0 high");
        step(3); exp_out(0, 1'b1, "R4 mode0 holds high");

        // R4 mode 1 on ch1, count 3, low byte only; R8 retrigger
        wr(2'd3, 8'h52); gate[1] = 1'b0;
        wr(2'd1, 8'h03);
        exp_out(1, 1'b1, "R4 mode1 high after load");
        step(2); exp_out(1, 1'b1, "R4 mode1 high at d=2");
        step(1); exp_out(1, 1'b0, "R4 mode1 low at d=3");
        step(2); exp_out(1, 1'b0, "R4 mode1 holds low");
        gate[1] = 1'b1;
        step(1); exp_out(1, 1'b1, "R8 mode1 gate rise restarts");
        step(2); exp_out(1, 1'b1, "R8 mode1 restarted d=2");
        step(1); exp_out(1, 1'b0, "R8 mode1 restarted d=3");

        // R5 mode 2 on ch2, count 4
        wr(2'd3, 8'h94); wr(2'd2, 8'h04);
        exp_out(2, 1'b1, "R5 high at load");
        step(3); exp_out(2, 1'b1, "R5 high d=3");
        step(1); exp_out(2, 1'b0, "R5 low d=4");
        step(1); exp_out(2, 1'b1, "R5 high d=5");
        step(3); exp_out(2, 1'b0, "R5 low d=8");

        // R6 mode 3 odd count 5 on ch0
        wr(2'd3, 8'h36); wr(2'd0, 8'h05); wr(2'd0, 8'h00);
        exp_out(0, 1'b1, "R6 high d=0");
        step(2); exp_out(0, 1'b1, "R6 high d=2");
        step(1); exp_out(0, 1'b0, "R6 low d=3");
        step(1); exp_out(0, 1'b0, "R6 low d=4");
        step(1); exp_out(0, 1'b1, "R6 high d=5");
        // R6 code 7 alias, even count 4
        wr(2'd3, 8'h3E); wr(2'd0, 8'h04); wr(2'd0, 8'h00);
        step(1); exp_out(0, 1'b1, "R6 alias high d=1");
        step(1); exp_out(0, 1'b0, "R6 alias low d=2");
        step(2); exp_out(0, 1'b1, "R6 alias high d=4");

        // R7 mode 4 on ch1, count 3; R8 gate ignored in mode 4
        wr(2'd3, 8'h58); gate[1] = 1'b0;
        wr(2'd1, 8'h03);
        gate[1] = 1'b1;
        step(1); exp_out(1, 1'b1, "R8 mode4 gate ignored d=1");
        step(1); exp_out(1, 1'b1, "R7 mode4 high d=2");
        step(1); exp_out(1, 1'b0, "R7 R8 mode4 strobe at d=3");
        step(1); exp_out(1, 1'b1, "R7 mode4 back high");
        step(5); exp_out(1, 1'b1, "R7 mode4 no second strobe");

        // R7 mode 5 on ch2, count 2; R8 retrigger
        wr(2'd3, 8'h9A); wr(2'd2, 8'h02);
        step(1); exp_out(2, 1'b1, "R7 mode5 high d=1");
        gate[2] = 1'b1;
        step(1); exp_out(2, 1'b1, "R8 mode5 restart d=0");
        step(1); exp_out(2, 1'b1, "R8 mode5 d=1");
        step(1); exp_out(2, 1'b0, "R7 mode5 strobe d=2");
        step(1); exp_out(2, 1'b1, "R7 mode5 back high");

        // R3 zero count means 65536
        wr(2'd3, 8'h70); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
        step(2);
        wr(2'd3, 8'h40);
        rd(2'd1, 8'hFE, "R3 zero load low byte");
        rd(2'd1, 8'hFF, "R3 zero load high byte");

        // R10 latch with simultaneous tick, ignored second latch; R11 live readback
        wr(2'd3, 8'h30); wr(2'd0, 8'h00); wr(2'd0, 8'h03);
        step(10);
        wr(2'd3, 8'h00);
        step(2);
        wr(2'd3, 8'h00);
        rd(2'd0, 8'hF6, "R10 latched low byte");
        rd(2'd0, 8'h02, "R10 latched high byte");
        rd(2'd0, 8'hF0, "R11 live low byte");
        rd(2'd0, 8'h02, "R11 live high byte");

        // R9 control word resets the toggle
        wr(2'd3, 8'hB0); wr(2'd2, 8'h11);
        wr(2'd3, 8'hB0); wr(2'd2, 8'h22); wr(2'd2, 8'h00);
        wr(2'd3, 8'h80);
        rd(2'd2, 8'h22, "R9 toggle reset low byte");
        rd(2'd2, 8'h00, "R9 toggle reset high byte");
        // R9 high byte only access
        wr(2'd3, 8'hA0); wr(2'd2, 8'h01);
        wr(2'd3, 8'h80);
        rd(2'd2, 8'h01, "R9 high-only latched");
        rd(2'd2, 8'h00, "R9 high-only live");

        // R12 BCD count 100
        wr(2'd3, 8'h31); wr(2'd0, 8'h00); wr(2'd0, 8'h01);
        step(1);
        wr(2'd3, 8'h00);
        rd(2'd0, 8'h99, "R12 bcd low digits");
        rd(2'd0, 8'h00, "R12 bcd high digits");
        // R3 R12 BCD zero means 10000
        wr(2'd3, 8'h71); wr(2'd1, 8'h00); wr(2'd1, 8'h00);
        step(2);
        wr(2'd3, 8'h40);
        rd(2'd1, 8'h98, "R12 bcd zero low digits");
        rd(2'd1, 8'h99, "R3 bcd zero high digits");

        step(2);
        finish_run();
    end
endmodule